// File: doc/BRIEF.md
# Multi-Queue Shared-SRAM FIFO Manager

This block provides 64 independent word FIFOs whose storage is carved out of one on-chip SRAM. Each queue's size, placement and watermarks are set at run time by writing a single packed configuration word. A host reaches the block through a simple single-beat register bus. The bus has an access window for pushing and popping each queue, a configuration window, and a status window that reports the queue's fill conditions.

Each queue owns a read pointer, a write pointer and an occupancy count. The SRAM address of an entry is the queue's base page times the page size plus the pointer, and each pointer wraps at the queue's size. Every read returns its data on the cycle after the request. Writes give no response.

Top module: `mq_fifo_mgr`

## Requirements
- R1: Configuration region (reqAddr = {2'b10, queue}). Bits 25:24 give the size (0, 1, 2 and 3 mean 16, 32, 64 and 128 words). Bits 21:14 give the base page, where one page is 16 words. Bits 28:26 hold the nearly-empty code and bits 31:29 hold the nearly-full code. Reading the region returns the word last written.
- R2: Access region (reqAddr = {2'b00, queue}). A write appends the data word. A read removes and returns the oldest word. A read raises respValid for exactly the following cycle, and a write leaves respValid low.
- R3: A push to a full queue drops its data. For queues 0 to 31 it also sets a sticky overflow flag, reported in status bit 4. Queues 32 to 63 never report overflow.
- R4: A pop from an empty queue returns zero and leaves the queue's count and pointers unchanged.
- R5: Writing a configuration word empties that queue and clears its overflow flag.
- R6: A queue is disabled when any of these holds: its configuration word is zero, its base page is below 4, or its base page plus its page count exceeds 128. A disabled queue drops pushes without setting overflow, and its pops return zero.
- R7: Status region (reqAddr = {2'b11, queue}). A read returns bit 0 = empty (count 0) and bit 3 = full (count equals size). All bits above 4 are zero.
- R8: Status bit 1 (nearly empty) is set when the count is at most the nearly-empty code. Status bit 2 (nearly full) is set when the free space is at most the nearly-full code.
- R9: Pointers wrap at the queue size, so FIFO order holds across many wraps. Queues in distinct pages do not disturb each other.
- R10: After reset every configuration word is zero, every queue reads status 0x03, and respValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request strobe, one beat per cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 8 | {region[1:0], queue[5:0]} |
| reqWdata | input | 32 | Write data (entry or configuration word) |
| respValid | output | 1 | Read data valid, one cycle after a read request |
| respData | output | 32 | Read data |

## Verification
The bench fills a queue to its full size and one entry beyond. A design that stored the extra word would return it among the popped data, and one that missed the overflow flag, or raised it on an upper-half queue, would show the wrong status bit 4. The bench pops past empty and checks that the result is zero and that later data is unaffected; a design that moved its pointers on an empty pop would read stale words. It drives a 16-word queue through several pointer wraps, where a bad size mask would scramble the order. It checks the watermark thresholds exactly at the boundary count. It also programs queues in the reserved pages and past the end of the SRAM, which a missing range check would accept as live storage.

// File: rtl/qmgr_pkg.sv
package qmgr_pkg;
  // configuration word layout (decoded by the datapath)
  localparam int CFG_W    = 32;
  localparam int BASE_LSB = 14;
  localparam int BASE_W   = 8;
  localparam int SIZE_LSB = 24;
  localparam int SIZE_W   = 2;
  localparam int NE_LSB   = 26;
  localparam int NF_LSB   = 29;
  localparam int MARK_W   = 3;

  // status word bit positions
  localparam int ST_W     = 5;
  localparam int ST_EMPTY = 0;
  localparam int ST_NEMP  = 1;
  localparam int ST_NFUL  = 2;
  localparam int ST_FULL  = 3;
  localparam int ST_OVF   = 4;

  // address regions
  localparam logic [1:0] RG_ACCESS = 2'b00;
  localparam logic [1:0] RG_CONFIG = 2'b10;
  localparam logic [1:0] RG_STATUS = 2'b11;

  typedef struct packed {
    logic push;
    logic pop;
    logic cfgWr;
    logic cfgRd;
    logic statRd;
  } qmStrobe_t;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_POP  = 2'd1,
    RK_CFG  = 2'd2,
    RK_STAT = 2'd3
  } respKind_e;
endpackage

// File: rtl/qmgr_sram.sv
module qmgr_sram #(
  parameter int DEPTH  = 2048,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [AW-1:0]     rdAddr,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
    if (rdEn) rdData <= mem[rdAddr];
  end
endmodule

// File: rtl/qmgr_ctrl.sv
module qmgr_ctrl
  import qmgr_pkg::*;
#(
  parameter int QID_W  = 6,
  parameter int DATA_W = 32,
  localparam int ADDR_W = QID_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output qmStrobe_t         strb,
  output logic [QID_W-1:0]  qSel,
  input  logic [DATA_W-1:0] popData,
  input  logic              popZero,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic [ST_W-1:0]   statData,
  output logic              respValid,
  output logic [DATA_W-1:0] respData
);
  logic [1:0] region;
  respKind_e  kindNext, kindQ;

  assign region = reqAddr[ADDR_W-1 -: 2];
  assign qSel   = reqAddr[QID_W-1:0];

  always_comb begin
    strb     = '0;
    kindNext = RK_NONE;
    if (reqValid) begin
      unique case (region)
        RG_ACCESS: begin
          strb.push = reqWrite;
          strb.pop  = !reqWrite;
          kindNext  = RK_POP;
        end
        RG_CONFIG: begin
          strb.cfgWr = reqWrite;
          strb.cfgRd = !reqWrite;
          kindNext   = RK_CFG;
        end
        RG_STATUS: begin
          strb.statRd = !reqWrite;
          kindNext    = RK_STAT;
        end
        default: kindNext = RK_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      respValid <= 1'b0;
      kindQ     <= RK_NONE;
    end else begin
      respValid <= reqValid && !reqWrite;
      kindQ     <= kindNext;
    end
  end

  always_comb begin
    unique case (kindQ)
      RK_POP:  respData = popZero ? '0 : popData;
      RK_CFG:  respData = DATA_W'(cfgData);
      RK_STAT: respData = DATA_W'(statData);
      default: respData = '0;
    endcase
  end

  // R2: one queue operation per request beat
  p_single_op_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.push, strb.pop, strb.cfgWr, strb.cfgRd, strb.statRd}));

  // R2: a read request is answered on the next cycle
  p_read_answered_r2: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !reqWrite) |=> respValid);
endmodule

// File: rtl/qmgr_datapath.sv
module qmgr_datapath
  import qmgr_pkg::*;
#(
  parameter int NUM_QUEUES = 64,
  parameter int DATA_W     = 32,
  parameter int PAGE_WORDS = 16,
  parameter int NUM_PAGES  = 128,
  parameter int RSVD_PAGES = 4,
  localparam int QID_W     = $clog2(NUM_QUEUES)
) (
  input  logic              clk,
  input  logic              rst,
  input  qmStrobe_t         strb,
  input  logic [QID_W-1:0]  qSel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] popData,
  output logic              popZero,
  output logic [CFG_W-1:0]  cfgData,
  output logic [ST_W-1:0]   statData
);
  localparam int HALF    = NUM_QUEUES / 2;
  localparam int HQ_W    = QID_W - 1;
  localparam int MAX_WDS = PAGE_WORDS << ((1 << SIZE_W) - 1);
  localparam int OFS_W   = $clog2(MAX_WDS);
  localparam int CNT_W   = OFS_W + 1;
  localparam int DEPTH   = PAGE_WORDS * NUM_PAGES;
  localparam int SADDR_W = $clog2(DEPTH);
  localparam int PG_SH   = $clog2(PAGE_WORDS);
  localparam int PGC_W   = BASE_W + 2;

  logic [CFG_W-1:0] cfgArr [NUM_QUEUES];
  logic [OFS_W-1:0] rdPtr  [NUM_QUEUES];
  logic [OFS_W-1:0] wrPtr  [NUM_QUEUES];
  logic [CNT_W-1:0] cnt    [NUM_QUEUES];
  logic [HALF-1:0]  ovf;

  logic [CFG_W-1:0]  selCfg;
  logic [SIZE_W-1:0] selCode;
  logic [BASE_W-1:0] selBase;
  logic [MARK_W-1:0] selNe, selNf;
  logic [CNT_W-1:0]  selSize, selCount;
  logic [OFS_W-1:0]  selMask, rdNext, wrNext;
  logic [PGC_W-1:0]  selPages;
  logic              selEnabled, selEmpty, selFull, isLow, selOvf;
  logic [HQ_W-1:0]   qLow;
  logic [ST_W-1:0]   selStat;
  logic              doPush, doPop, pushDrop;
  logic [SADDR_W-1:0] baseWord, sramWrAddr, sramRdAddr;

  // configuration decode for the addressed queue
  assign selCfg   = cfgArr[qSel];
  assign selCode  = selCfg[SIZE_LSB +: SIZE_W];
  assign selBase  = selCfg[BASE_LSB +: BASE_W];
  assign selNe    = selCfg[NE_LSB +: MARK_W];
  assign selNf    = selCfg[NF_LSB +: MARK_W];
  assign selSize  = CNT_W'(PAGE_WORDS) << selCode;
  assign selMask  = OFS_W'(selSize - CNT_W'(1));
  assign selPages = PGC_W'(1) << selCode;

  assign selEnabled = (|selCfg)
                   && (PGC_W'(selBase) >= PGC_W'(RSVD_PAGES))
                   && (PGC_W'(selBase) + selPages <= PGC_W'(NUM_PAGES));

  assign selCount = cnt[qSel];
  assign selEmpty = (selCount == '0);
  assign selFull  = (selCount == selSize);

  assign isLow  = !qSel[QID_W-1];
  assign qLow   = qSel[HQ_W-1:0];
  assign selOvf = isLow && ovf[qLow];

  always_comb begin
    selStat           = '0;
    selStat[ST_EMPTY] = selEmpty;
    selStat[ST_FULL]  = selFull;
    selStat[ST_NEMP]  = selCount <= CNT_W'(selNe);
    selStat[ST_NFUL]  = (selSize - selCount) <= CNT_W'(selNf);
    selStat[ST_OVF]   = selOvf;
  end

  // operation qualification
  assign doPush   = strb.push && selEnabled && !selFull;
  assign pushDrop = strb.push && selEnabled && selFull;
  assign doPop    = strb.pop && selEnabled && !selEmpty;

  assign rdNext = (rdPtr[qSel] + OFS_W'(1)) & selMask;
  assign wrNext = (wrPtr[qSel] + OFS_W'(1)) & selMask;

  assign baseWord   = SADDR_W'(selBase) << PG_SH;
  assign sramWrAddr = baseWord + SADDR_W'(wrPtr[qSel]);
  assign sramRdAddr = baseWord + SADDR_W'(rdPtr[qSel]);

  qmgr_sram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_sram (
    .clk    (clk),
    .wrEn   (doPush),
    .wrAddr (sramWrAddr),
    .wrData (wdata),
    .rdEn   (doPop),
    .rdAddr (sramRdAddr),
    .rdData (popData)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_QUEUES; i++) begin
        cfgArr[i] <= '0;
        rdPtr[i]  <= '0;
        wrPtr[i]  <= '0;
        cnt[i]    <= '0;
      end
      ovf      <= '0;
      popZero  <= 1'b1;
      cfgData  <= '0;
      statData <= '0;
    end else begin
      if (strb.cfgWr) begin
        cfgArr[qSel] <= wdata[CFG_W-1:0];
        rdPtr[qSel]  <= '0;
        wrPtr[qSel]  <= '0;
        cnt[qSel]    <= '0;
        if (isLow) ovf[qLow] <= 1'b0;
      end
      if (doPush) begin
        wrPtr[qSel] <= wrNext;
        cnt[qSel]   <= selCount + CNT_W'(1);
      end
      if (pushDrop && isLow) ovf[qLow] <= 1'b1;
      if (doPop) begin
        rdPtr[qSel] <= rdNext;
        cnt[qSel]   <= selCount - CNT_W'(1);
      end
      if (strb.pop)    popZero  <= !doPop;
      if (strb.cfgRd)  cfgData  <= selCfg;
      if (strb.statRd) statData <= selStat;
    end
  end

  // R3: a push into a full lower-half queue keeps the count and raises overflow
  p_full_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (strb.push && selEnabled && selFull && isLow)
      |=> (ovf[$past(qLow)] && cnt[$past(qSel)] == $past(selCount)));

  // R4: an empty pop leaves the count at zero and yields a zero response
  p_empty_pop_r4: assert property (@(posedge clk) disable iff (rst)
    (strb.pop && selEmpty) |=> (cnt[$past(qSel)] == '0 && popZero));

  // R5: a configuration write empties the queue
  p_cfg_clear_r5: assert property (@(posedge clk) disable iff (rst)
    strb.cfgWr |=> (cnt[$past(qSel)] == '0));

  // R7: occupancy never exceeds the programmed size
  p_count_bound_r7: assert property (@(posedge clk) disable iff (rst)
    selEnabled |-> (selCount <= selSize));
endmodule

// File: rtl/mq_fifo_mgr.sv
module mq_fifo_mgr
  import qmgr_pkg::*;
#(
  parameter int NUM_QUEUES = 64,
  parameter int DATA_W     = 32,
  parameter int PAGE_WORDS = 16,
  parameter int NUM_PAGES  = 128,
  parameter int RSVD_PAGES = 4,
  localparam int QID_W     = $clog2(NUM_QUEUES),
  localparam int ADDR_W    = QID_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              respValid,
  output logic [DATA_W-1:0] respData
);
  qmStrobe_t         strb;
  logic [QID_W-1:0]  qSel;
  logic [DATA_W-1:0] popData;
  logic              popZero;
  logic [CFG_W-1:0]  cfgData;
  logic [ST_W-1:0]   statData;

  qmgr_ctrl #(.QID_W(QID_W), .DATA_W(DATA_W)) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqAddr   (reqAddr),
    .strb      (strb),
    .qSel      (qSel),
    .popData   (popData),
    .popZero   (popZero),
    .cfgData   (cfgData),
    .statData  (statData),
    .respValid (respValid),
    .respData  (respData)
  );

  qmgr_datapath #(
    .NUM_QUEUES (NUM_QUEUES),
    .DATA_W     (DATA_W),
    .PAGE_WORDS (PAGE_WORDS),
    .NUM_PAGES  (NUM_PAGES),
    .RSVD_PAGES (RSVD_PAGES)
  ) i_datapath (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .qSel     (qSel),
    .wdata    (reqWdata),
    .popData  (popData),
    .popZero  (popZero),
    .cfgData  (cfgData),
    .statData (statData)
  );
endmodule

// File: tb/test_mq_fifo_mgr.sv
`timescale 1ns/1ps
module test_mq_fifo_mgr;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [7:0]  reqAddr  = '0;
  logic [31:0] reqWdata = '0;
  logic        respValid;
  logic [31:0] respData;

  int nChecks = 0;
  int nFail   = 0;

  always #10 clk = ~clk;

  mq_fifo_mgr i_mq_fifo_mgr (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata),
    .respValid(respValid), .respData(respData)
  );

  // vector: op[3] queue[6] data[32] expected[32] requirement[4]
  // op: 0 config write, 1 push, 2 pop, 3 status read, 4 config read
  localparam int NV = 18;
  localparam logic [76:0] VEC [NV] = '{
    {3'd0, 6'd1,  32'h6801_0000, 32'h0,          4'd1},  // R1
    {3'd4, 6'd1,  32'h0,         32'h6801_0000,  4'd1},  // R1
    {3'd3, 6'd1,  32'h0,         32'h03,         4'd8},  // R8
    {3'd1, 6'd1,  32'hA1,        32'h0,          4'd2},  // R2
    {3'd1, 6'd1,  32'hA2,        32'h0,          4'd2},
    {3'd1, 6'd1,  32'hA3,        32'h0,          4'd2},
    {3'd3, 6'd1,  32'h0,         32'h00,         4'd8},
    {3'd2, 6'd1,  32'h0,         32'hA1,         4'd2},
    {3'd2, 6'd1,  32'h0,         32'hA2,         4'd2},
    {3'd3, 6'd1,  32'h0,         32'h02,         4'd8},
    {3'd2, 6'd1,  32'h0,         32'hA3,         4'd2},
    {3'd2, 6'd1,  32'h0,         32'h0,          4'd4},  // R4
    {3'd3, 6'd1,  32'h0,         32'h03,         4'd4},
    {3'd0, 6'd40, 32'h0102_0000, 32'h0,          4'd1},
    {3'd1, 6'd40, 32'hB1,        32'h0,          4'd9},  // R9
    {3'd3, 6'd40, 32'h0,         32'h00,         4'd7},  // R7
    {3'd2, 6'd40, 32'h0,         32'hB1,         4'd9},
    {3'd3, 6'd1,  32'h0,         32'h03,         4'd9}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busOp(input logic wr, input logic [1:0] rg, input logic [5:0] q,
                       input logic [31:0] d, output logic [31:0] rd, output logic rv);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = {rg, q}; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    rd = respData; rv = respValid;
  endtask

  task automatic doPush(input logic [5:0] q, input logic [31:0] d);
    logic [31:0] rd; logic rv;
    busOp(1'b1, 2'b00, q, d, rd, rv);
  endtask

  task automatic doCfg(input logic [5:0] q, input logic [31:0] d);
    logic [31:0] rd; logic rv;
    busOp(1'b1, 2'b10, q, d, rd, rv);
  endtask

  task automatic doPop(input logic [5:0] q, output logic [31:0] rd);
    logic rv;
    busOp(1'b0, 2'b00, q, '0, rd, rv);
  endtask

  task automatic doStat(input logic [5:0] q, output logic [31:0] rd);
    logic rv;
    busOp(1'b0, 2'b11, q, '0, rd, rv);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks + 1, nFail);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    logic        rv;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R10: reset state
    chk("R10 respValid after reset", {31'b0, respValid}, 32'h0);
    doStat(6'd0, rd);
    chk("R10 status of queue 0", rd, 32'h03);
    busOp(1'b0, 2'b10, 6'd63, '0, rd, rv);
    chk("R10 config of queue 63", rd, 32'h0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [2:0]  op;
      logic [5:0]  q;
      logic [31:0] d, e;
      logic [3:0]  r;
      string       tag;
      {op, q, d, e, r} = VEC[v];
      tag = $sformatf("R%0d vector %0d", r, v);
      case (op)
        3'd0: begin busOp(1'b1, 2'b10, q, d, rd, rv); chk({tag, " no response"}, {31'b0, rv}, 32'h0); end
        3'd1: begin busOp(1'b1, 2'b00, q, d, rd, rv); chk({tag, " no response"}, {31'b0, rv}, 32'h0); end
        3'd2: begin busOp(1'b0, 2'b00, q, d, rd, rv); chk({tag, " valid"}, {31'b0, rv}, 32'h1); chk(tag, rd, e); end
        3'd3: begin busOp(1'b0, 2'b11, q, d, rd, rv); chk(tag, rd, e); end
        default: begin busOp(1'b0, 2'b10, q, d, rd, rv); chk({tag, " valid"}, {31'b0, rv}, 32'h1); chk(tag, rd, e); end
      endcase
    end

    // R3 R7 R8: fill queue 2 (16 words, nearly-full code 2) and overflow it
    doCfg(6'd2, 32'h4001_4000);
    for (int i = 0; i < 13; i++) doPush(6'd2, 32'h200 + i);
    doStat(6'd2, rd); chk("R8 count 13 no watermark", rd, 32'h00);
    doPush(6'd2, 32'h20D);
    doStat(6'd2, rd); chk("R8 nearly full at free 2", rd, 32'h04);
    doPush(6'd2, 32'h20E);
    doPush(6'd2, 32'h20F);
    doStat(6'd2, rd); chk("R7 full", rd, 32'h0C);
    doPush(6'd2, 32'hDEAD);
    doStat(6'd2, rd); chk("R3 overflow sticky", rd, 32'h1C);
    for (int i = 0; i < 16; i++) begin
      doPop(6'd2, rd); chk("R3 order, dropped word absent", rd, 32'h200 + i);
    end
    doPop(6'd2, rd); chk("R4 pop past empty", rd, 32'h0);
    doStat(6'd2, rd); chk("R3 overflow survives drain", rd, 32'h13);

    // R5: reconfigure clears count and overflow
    doPush(6'd2, 32'h77);
    doCfg(6'd2, 32'h4001_4000);
    doStat(6'd2, rd); chk("R5 empty after reconfigure", rd, 32'h03);
    doPop(6'd2, rd); chk("R5 pop after reconfigure", rd, 32'h0);

    // R3: upper-half queue 40 (32 words) never flags overflow
    for (int i = 0; i < 33; i++) doPush(6'd40, 32'h400 + i);
    doStat(6'd40, rd); chk("R3 upper half no overflow", rd, 32'h0C);
    doPop(6'd40, rd); chk("R3 upper half head", rd, 32'h400);

    // R9: wrap a 16-word queue several times
    for (int i = 0; i < 10; i++) doPush(6'd1, 32'h1000 + i);
    for (int i = 0; i < 30; i++) begin
      doPush(6'd1, 32'h1000 + 10 + i);
      doPop(6'd1, rd); chk("R9 order across wrap", rd, 32'h1000 + i);
    end
    doStat(6'd1, rd); chk("R9 count after wrap", rd, 32'h00);

    // R1: size codes 3 and 2
    doCfg(6'd5, 32'h0304_0000);
    for (int i = 0; i < 128; i++) doPush(6'd5, 32'h3000 + i);
    doStat(6'd5, rd); chk("R1 128-word queue full", rd, 32'h0C);
    doPop(6'd5, rd); chk("R1 128-word queue head", rd, 32'h3000);
    doCfg(6'd6, 32'h0206_0000);
    for (int i = 0; i < 63; i++) doPush(6'd6, 32'h6000 + i);
    doStat(6'd6, rd); chk("R1 64-word queue at 63", rd, 32'h00);
    doPush(6'd6, 32'h603F);
    doStat(6'd6, rd); chk("R1 64-word queue full", rd, 32'h0C);

    // R6: disabled queues
    doCfg(6'd3, 32'h0000_8000);
    doPush(6'd3, 32'h55);
    doStat(6'd3, rd); chk("R6 reserved page status", rd, 32'h03);
    doPop(6'd3, rd); chk("R6 reserved page pop", rd, 32'h0);
    doCfg(6'd7, 32'h031F_0000);
    doPush(6'd7, 32'h66);
    doPop(6'd7, rd); chk("R6 past end of SRAM pop", rd, 32'h0);
    doPush(6'd4, 32'h88);
    doStat(6'd4, rd); chk("R6 zero config status", rd, 32'h03);
    doPop(6'd4, rd); chk("R6 zero config pop", rd, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule